// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This block hangs off a simple processor bus and offers three byte-wide parallel ports, named A, B and C, plus one configuration location. Two address bits pick the location, an active-low chip select gates every access, and active-low read and write strobes give the direction. The shared data bus is split into an input byte, an output byte and an output-enable. Port reads are combinational, so the value appears on the bus in the same cycle as the strobe. Writes take effect on the rising clock edge.

Two groups share the ports. Group A is port A plus the upper nibble of port C. Group B is port B plus the lower nibble of port C. The configuration word sets a direction for port A, port B and each half of port C. It also carries a mode field for each group, and every mode behaves as plain latched output or direct input. A write to the configuration location with the top data bit clear does not change the configuration. It is a command that sets or clears one chosen bit of port C, so software can drive single control lines without touching the other bits.

Top module: `ppi_top`

## Requirements
- R1: The location is decoded as addr 0 = port A, 1 = port B, 2 = port C, 3 = configuration. When a port is set as an output, a read of that port drives its output latch onto `dout`, with `dout_oe` high.
- R2: When a port is set as an input, a read of that port returns the level on its input pins.
- R3: While `sel_n` is high, `dout_oe` is low, whatever the other inputs are.
- R4: While `rd_n` and `wr_n` are both high, `dout_oe` is low.
- R5: A read of location 3 is an illegal access and leaves `dout_oe` low.
- R6: A write to location 3 with data bit 7 = 1 loads a new configuration and clears every output latch to 0 on the same clock edge. The direction bits are: bit 4 for port A, bit 3 for port C upper, bit 1 for port B, bit 0 for port C lower. A value of 1 means input. Each drive-enable output is the inverse of its direction bit.
- R7: A write to location 3 with data bit 7 = 0 changes only port C latch bit `din[3:1]`, setting it to `din[0]`. Bits 6:4 are ignored, and the configuration is unchanged.
- R8: A bit command updates the port C latch even when that half of port C is set as an input. `pc_out` always shows the latch.
- R9: After reset, all four drive enables are low (every port is an input) and all latches read 0.
- R10: The two halves of port C follow their own direction bits. A port C read combines pin levels for an input half with latch bits for an output half.
- R11: The mode fields (bits 6:5 for group A, bit 2 for group B) are accepted with any value, and the ports behave as plain latched output or direct input.
- R12: A write strobe while `sel_n` is high changes no latch and no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Location select |
| din | input | 8 | Data bus into the block |
| dout | output | 8 | Data bus out of the block |
| dout_oe | output | 1 | Drive enable for the data bus |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_drive | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_drive | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_hi_drive | output | 1 | Drive enable, port C bits 7:4 |
| pc_lo_drive | output | 1 | Drive enable, port C bits 3:0 |

## Verification
Read data and `dout_oe` are combinational, so they are valid in the same cycle the strobe and address are applied. The bench drives them just after a rising edge and compares them at the following falling edge. Latch and drive-enable changes come from a write captured on one rising edge. These results are expected from that edge onward, so the bench queues them once the strobe is released and compares them at the next falling edge. Nothing is sampled near an active edge.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

  typedef enum logic [1:0] {
    LOC_PORT_A = 2'd0,
    LOC_PORT_B = 2'd1,
    LOC_PORT_C = 2'd2,
    LOC_CONFIG = 2'd3
  } ppi_loc_e;

  // Direction settings, 1 = input
  typedef struct packed {
    logic a_in;
    logic c_hi_in;
    logic b_in;
    logic c_lo_in;
  } ppi_dir_t;

  localparam ppi_dir_t DIR_ALL_INPUT = '{a_in: 1'b1, c_hi_in: 1'b1, b_in: 1'b1, c_lo_in: 1'b1};

  localparam int NUM_PORTS = 3;

endpackage

// File: rtl/ppi_bus_decode.sv
module ppi_bus_decode
  import ppi_pkg::*;
(
  input  logic       sel_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic       cmd_msb,
  output logic       rd_drive,
  output logic [2:0] port_load,
  output logic       cfg_load,
  output logic       bit_cmd
);

  logic access;
  logic rd_cycle;
  logic wr_cycle;
  logic at_cfg;

  always_comb begin
    access   = ~sel_n;
    rd_cycle = access & ~rd_n & wr_n;
    wr_cycle = access & ~wr_n & rd_n;
    at_cfg   = (ppi_loc_e'(addr) == LOC_CONFIG);

    rd_drive = rd_cycle & ~at_cfg;

    port_load[0] = wr_cycle & (ppi_loc_e'(addr) == LOC_PORT_A);
    port_load[1] = wr_cycle & (ppi_loc_e'(addr) == LOC_PORT_B);
    port_load[2] = wr_cycle & (ppi_loc_e'(addr) == LOC_PORT_C);

    cfg_load = wr_cycle & at_cfg & cmd_msb;
    bit_cmd  = wr_cycle & at_cfg & ~cmd_msb;
  end

endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_load,
  input  ppi_dir_t dir_wdata,
  output ppi_dir_t dir_q
);

  ppi_dir_t dir_nxt;

  always_comb begin
    dir_nxt = dir_q;
    if (cfg_load) dir_nxt = dir_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dir_q <= DIR_ALL_INPUT;
    else if (cfg_load) dir_q <= dir_nxt;
  end

endmodule

// File: rtl/ppi_port_latch.sv
module ppi_port_latch #(
  parameter int PORT_W  = 8,
  parameter bit BIT_OPS = 1'b0,
  localparam int IDX_W  = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [PORT_W-1:0] wdata,
  input  logic              bit_we,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_val,
  output logic [PORT_W-1:0] q
);

  logic [PORT_W-1:0] q_nxt;
  logic              q_en;

  generate
    if (BIT_OPS) begin : g_bitops
      always_comb begin
        q_nxt = q;
        if (clear)       q_nxt = '0;
        else if (load)   q_nxt = wdata;
        else if (bit_we) q_nxt[bit_idx] = bit_val;
        q_en = clear | load | bit_we;
      end
    end else begin : g_plain
      logic unused_bits;
      always_comb begin
        unused_bits = bit_we ^ bit_val ^ (^bit_idx);
        q_nxt = q;
        if (clear)     q_nxt = '0;
        else if (load) q_nxt = wdata;
        q_en = clear | load;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
  import ppi_pkg::*;
#(
  parameter int PORT_W  = 8,
  localparam int HALF_W = PORT_W / 2
) (
  input  logic [1:0]        addr,
  input  ppi_dir_t          dir,
  input  logic [PORT_W-1:0] lat_a,
  input  logic [PORT_W-1:0] lat_b,
  input  logic [PORT_W-1:0] lat_c,
  input  logic [PORT_W-1:0] pin_a,
  input  logic [PORT_W-1:0] pin_b,
  input  logic [PORT_W-1:0] pin_c,
  output logic [PORT_W-1:0] rdata
);

  logic [PORT_W-1:0] view_a;
  logic [PORT_W-1:0] view_b;
  logic [PORT_W-1:0] view_c;

  always_comb begin
    view_a = dir.a_in ? pin_a : lat_a;
    view_b = dir.b_in ? pin_b : lat_b;
    view_c[PORT_W-1:HALF_W] = dir.c_hi_in ? pin_c[PORT_W-1:HALF_W] : lat_c[PORT_W-1:HALF_W];
    view_c[HALF_W-1:0]      = dir.c_lo_in ? pin_c[HALF_W-1:0]      : lat_c[HALF_W-1:0];

    unique case (ppi_loc_e'(addr))
      LOC_PORT_A: rdata = view_a;
      LOC_PORT_B: rdata = view_b;
      LOC_PORT_C: rdata = view_c;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic              pa_drive,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic              pb_drive,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic              pc_hi_drive,
  output logic              pc_lo_drive
);

  localparam int IDX_W = $clog2(PORT_W);

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic       rd_drive;
  logic [2:0] port_load;
  logic       cfg_load;
  logic       bit_cmd;

  ppi_bus_decode u_decode (
    .sel_n     (sel_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .cmd_msb   (din[7]),
    .rd_drive  (rd_drive),
    .port_load (port_load),
    .cfg_load  (cfg_load),
    .bit_cmd   (bit_cmd)
  );

  ppi_dir_t dir_wdata;
  ppi_dir_t dir_q;

  always_comb begin
    dir_wdata.a_in    = din[4];
    dir_wdata.c_hi_in = din[3];
    dir_wdata.b_in    = din[1];
    dir_wdata.c_lo_in = din[0];
  end

  ppi_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_load  (cfg_load),
    .dir_wdata (dir_wdata),
    .dir_q     (dir_q)
  );

  logic [PORT_W-1:0] lat_q [NUM_PORTS];

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      ppi_port_latch #(
        .PORT_W  (PORT_W),
        .BIT_OPS (p == 2)
      ) u_latch (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .clear   (cfg_load),
        .load    (port_load[p]),
        .wdata   (din[PORT_W-1:0]),
        .bit_we  (bit_cmd),
        .bit_idx (din[IDX_W:1]),
        .bit_val (din[0]),
        .q       (lat_q[p])
      );
    end
  endgenerate

  ppi_read_mux #(.PORT_W(PORT_W)) u_rmux (
    .addr  (addr),
    .dir   (dir_q),
    .lat_a (lat_q[0]),
    .lat_b (lat_q[1]),
    .lat_c (lat_q[2]),
    .pin_a (pa_in),
    .pin_b (pb_in),
    .pin_c (pc_in),
    .rdata (dout)
  );

  always_comb begin
    dout_oe     = rd_drive;
    pa_out      = lat_q[0];
    pb_out      = lat_q[1];
    pc_out      = lat_q[2];
    pa_drive    = ~dir_q.a_in;
    pb_drive    = ~dir_q.b_in;
    pc_hi_drive = ~dir_q.c_hi_in;
    pc_lo_drive = ~dir_q.c_lo_in;
  end

endmodule

// File: rtl/ppi_top_chk.sv
module ppi_top_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] addr,
  input logic       cmd_msb,
  input logic       dout_oe,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out
);

  AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !dout_oe); // R3

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> !dout_oe); // R4

  AST_CFG_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> !dout_oe); // R5

  AST_CFG_CLEARS_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_n && rd_n && addr == 2'd3 && cmd_msb)
      |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)); // R6

  AST_BITCMD_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_n && rd_n && addr == 2'd3 && !cmd_msb)
      |=> ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out) && $stable(pb_out))); // R7

  AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out))); // R12

endmodule

bind ppi_top ppi_top_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .sel_n   (sel_n),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .addr    (addr),
  .cmd_msb (din[7]),
  .dout_oe (dout_oe),
  .pa_out  (pa_out),
  .pb_out  (pb_out),
  .pc_out  (pc_out)
);

// File: tb/tb_ppi_top.sv
module tb_ppi_top;

  localparam time CLK_T = 4ns;

  localparam int K_DOUT = 0;
  localparam int K_NOOE = 1;
  localparam int K_PA   = 2;
  localparam int K_PB   = 3;
  localparam int K_PC   = 4;
  localparam int K_EN   = 5;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } sb_item_t;

  logic       clk;
  logic       rst_n;
  logic       sel_n;
  logic       rd_n;
  logic       wr_n;
  logic [1:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic       dout_oe;
  logic [7:0] pa_in, pb_in, pc_in;
  logic [7:0] pa_out, pb_out, pc_out;
  logic       pa_drive, pb_drive, pc_hi_drive, pc_lo_drive;

  int compared;
  int mismatched;
  bit finished;
  sb_item_t sbq[$];

  ppi_top dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_n       (sel_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .addr        (addr),
    .din         (din),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .pa_in       (pa_in),
    .pa_out      (pa_out),
    .pa_drive    (pa_drive),
    .pb_in       (pb_in),
    .pb_out      (pb_out),
    .pb_drive    (pb_drive),
    .pc_in       (pc_in),
    .pc_out      (pc_out),
    .pc_hi_drive (pc_hi_drive),
    .pc_lo_drive (pc_lo_drive)
  );

  initial clk = 1'b0;
  always #(CLK_T / 2) clk = ~clk;

  // Monitor: compares every queued item at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        sb_item_t it;
        logic [7:0] act;
        logic ok;
        it = sbq.pop_front();
        ok = 1'b1;
        case (it.kind)
          K_DOUT: begin act = dout; ok = dout_oe && (dout == it.exp); end
          K_NOOE: begin act = {7'd0, dout_oe}; ok = !dout_oe; end
          K_PA:   begin act = pa_out; ok = (pa_out == it.exp); end
          K_PB:   begin act = pb_out; ok = (pb_out == it.exp); end
          K_PC:   begin act = pc_out; ok = (pc_out == it.exp); end
          default: begin
            act = {4'd0, pa_drive, pb_drive, pc_hi_drive, pc_lo_drive};
            ok  = (act == it.exp);
          end
        endcase
        compared++;
        if (!ok) begin
          mismatched++;
          $display("FAIL %s kind=%0d actual=%h (oe=%b) expected=%h", it.req, it.kind, act, dout_oe, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1ns;
  endtask

  task automatic expect_item(input int kind, input logic [7:0] exp, input string req);
    sb_item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.req  = req;
    sbq.push_back(it);
  endtask

  task automatic chk(input int kind, input logic [7:0] exp, input string req);
    expect_item(kind, exp, req);
    step();
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic select);
    sel_n = ~select;
    wr_n  = 1'b0;
    rd_n  = 1'b1;
    addr  = a;
    din   = d;
    step();
    sel_n = 1'b1;
    wr_n  = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string req);
    sel_n = 1'b0;
    rd_n  = 1'b0;
    wr_n  = 1'b1;
    addr  = a;
    expect_item(K_DOUT, exp, req);
    step();
    sel_n = 1'b1;
    rd_n  = 1'b1;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_T * 50000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      report();
    end
  end

  initial begin
    compared   = 0;
    mismatched = 0;
    finished   = 1'b0;
    rst_n = 1'b0;
    sel_n = 1'b1;
    rd_n  = 1'b1;
    wr_n  = 1'b1;
    addr  = 2'd0;
    din   = 8'h00;
    pa_in = 8'h5A;
    pb_in = 8'hE4;
    pc_in = 8'h30;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R9: reset state
    chk(K_EN, 8'h00, "R9");
    chk(K_PA, 8'h00, "R9");
    chk(K_PC, 8'h00, "R9");
    bus_read(2'd0, 8'h5A, "R2 R9");

    // R6: all outputs, mode 0
    bus_write(2'd3, 8'h80, 1'b1);
    chk(K_EN, 8'h0F, "R6");

    // R1: writes and reads of each output port
    bus_write(2'd0, 8'h3C, 1'b1);
    chk(K_PA, 8'h3C, "R1");
    bus_read(2'd0, 8'h3C, "R1");
    bus_write(2'd1, 8'hA5, 1'b1);
    bus_read(2'd1, 8'hA5, "R1");
    bus_write(2'd2, 8'h81, 1'b1);
    bus_read(2'd2, 8'h81, "R1");

    // R5: illegal read of the configuration location
    sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = 2'd3;
    chk(K_NOOE, 8'h00, "R5");
    // R3: read strobe without chip select
    sel_n = 1'b1; addr = 2'd0;
    chk(K_NOOE, 8'h00, "R3");
    // R4: selected but idle
    sel_n = 1'b0; rd_n = 1'b1;
    chk(K_NOOE, 8'h00, "R4");
    sel_n = 1'b1;

    // R7: bit commands, junk in bits 6:4
    bus_write(2'd3, 8'h7B, 1'b1);
    chk(K_PC, 8'hA1, "R7");
    chk(K_EN, 8'h0F, "R7");
    chk(K_PA, 8'h3C, "R7");
    bus_write(2'd3, 8'h0E, 1'b1);
    chk(K_PC, 8'h21, "R7");
    bus_write(2'd3, 8'h00, 1'b1);
    chk(K_PC, 8'h20, "R7");

    // R12: write strobe with chip select inactive
    bus_write(2'd0, 8'hFF, 1'b0);
    chk(K_PA, 8'h3C, "R12");
    bus_write(2'd3, 8'h9B, 1'b0);
    chk(K_EN, 8'h0F, "R12");

    // R6: configuration write clears latches
    bus_write(2'd3, 8'h80, 1'b1);
    chk(K_PA, 8'h00, "R6");
    chk(K_PB, 8'h00, "R6");
    chk(K_PC, 8'h00, "R6");

    // R10: port C upper input, lower output
    bus_write(2'd3, 8'h88, 1'b1);
    chk(K_EN, 8'h0D, "R10");
    bus_write(2'd2, 8'hFF, 1'b1);
    bus_read(2'd2, 8'h3F, "R10");

    // R8: bit command with port C fully input
    bus_write(2'd3, 8'h89, 1'b1);
    chk(K_EN, 8'h0C, "R8");
    bus_write(2'd3, 8'h0D, 1'b1);
    chk(K_PC, 8'h40, "R8");
    bus_read(2'd2, 8'h30, "R8");

    // R11: group A mode 2, group B mode 1, port B input
    bus_write(2'd3, 8'hC6, 1'b1);
    chk(K_EN, 8'h0B, "R11");
    bus_write(2'd0, 8'h77, 1'b1);
    bus_read(2'd0, 8'h77, "R11");
    bus_read(2'd1, 8'hE4, "R11");
    bus_write(2'd2, 8'h96, 1'b1);
    bus_read(2'd2, 8'h96, "R11");

    step();
    finished = 1'b1;
    report();
  end

endmodule